// File: doc/BRIEF.md
# LCD Panel Power-Up Sequencer

This block brings a 240x320 TFT panel controller out of reset and into a displaying state with no help from software. After a `start` pulse it pulses the panel reset line and synchronises the controller's index/data bus. It then reads the controller's identity register and gives up with a sticky error if the code is wrong. If the code matches, it replays a fixed program of register writes with millisecond pauses between groups, programs the drawing window, zero-fills the graphics memory and finally switches the display on. `done` then stays high.

The controller is reached through an 8080-style parallel bus running 16-bit transfers. Those 16 bits travel on an 18-line host data path. The low byte sits on lines 8:1 and the high byte on lines 17:10, while lines 0 and 9 are guard lines. A bus engine outside this block does the electrical timing. The sequencer only issues single-cycle index-write, data-write and data-read commands, and only in cycles where the engine reports `busReady`. The register tables live in an internal ROM. A parameter gives the clock cycles per millisecond, so every pause scales with the clock.

Top module: `panel_init_seq`

## Requirements
- R1: Out of reset `panelResetN` is 1. A run drives it to 0 for at least 2*CLK_PER_MS cycles and then back to 1. No bus command is issued while it is 0, nor within CLK_PER_MS cycles after it returns to 1.
- R2: Every written 16-bit word w appears on `wrWord` as {w[15:8], 1, w[7:0], 1}: bits 7:0 on lines 8:1, bits 15:8 on lines 17:10, and lines 0 and 9 at 1.
- R3: A register write is an `idxWr` carrying the register number, then a `datWr` carrying the value. A register read is an `idxWr`, then a `datRd`. `rdWord` is taken in the cycle after `datRd` as {lines 17:10, lines 8:1}, and lines 0 and 9 are ignored.
- R4: Four writes of 0 to register 0 precede a read of register 0. If that read is not ID_CODE (0x1505), `errO` rises, no further command is issued and `doneO` stays 0.
- R5: After a good identity read, the block issues, in order: four more writes of 0 to register 0; 0x0001 to register 0xA4; a pause of at least 10 ms; a 12-pair table; a pause of at least 100 ms; a 25-pair table; window writes 0x50=239-(V_RES-1), 0x51=0xEF, 0x52=0, 0x53=H_RES-1; a 4-pair table; a pause of at least 10 ms; a 3-pair table.
- R6: After a pause of at least 40 ms, registers 0x20 and 0x21 are set to 0. Register 0x22 is then written with 0 exactly H_RES*LINE_WORDS times, after which 0x20 and 0x21 are set to 0 again and 0x0173 is written to register 0x07.
- R7: After a pause of at least 40 ms, a single `idxWr` carrying 0x0022 is issued with no data cycle. `doneO` rises no earlier than 100 ms after it and stays 1, with no bus command, until the next accepted start.
- R8: A command strobe is asserted only in a cycle where `busReady` is 1, and at most one of `idxWr`, `datWr`, `datRd` is 1 in any cycle.
- R9: `errO` stays 1 until a start is accepted. An accepted start clears both `errO` and `doneO` in the following cycle.
- R10: A start pulse while a run is in progress has no effect, and the command sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted only when idle, done or in error) |
| busReady | input | 1 | Bus engine can take a command this cycle |
| rdWord | input | 18 | Read data lines, valid in the cycle after `datRd` |
| idxWr | output | 1 | Index-write command strobe |
| datWr | output | 1 | Data-write command strobe |
| datRd | output | 1 | Data-read command strobe |
| wrWord | output | 18 | Mapped word for the current index or data write |
| panelResetN | output | 1 | Active-low panel reset line |
| doneO | output | 1 | Bring-up finished, held until next start |
| errO | output | 1 | Identity mismatch, sticky until next start |

## Verification
Each command strobe is combinational on `busReady` within the same cycle, so the bench changes `busReady` just after the rising edge and reads strobes and `wrWord` at the falling edge of that same cycle. It compares them one by one with an expected command list that it builds from the requirements. The read response is placed on `rdWord` at the falling edge of the `datRd` cycle and held, so it is valid throughout the next cycle, where the sequencer compares it. `errO` and `doneO` are registered state and are checked one falling edge after the deciding edge. Pauses are checked as the number of cycles between consecutive commands, against the stated millisecond counts times CLK_PER_MS.

// File: rtl/panel_init_pkg.sv
package panel_init_pkg;

  typedef enum logic [3:0] {
    OP_RST_LO, OP_RST_HI, OP_WAIT, OP_WR, OP_FILL,
    OP_TBL, OP_RDCHK, OP_IDX, OP_END
  } op_e;

  // One program step: a = register or table start, b = value or expected code,
  // n = repeat count or milliseconds
  typedef struct packed {
    op_e         op;
    logic [15:0] a;
    logic [15:0] b;
    logic [23:0] n;
  } step_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic startRun;
    logic nextStep;
    logic loadCnt;
    logic decCnt;
    logic tick;
    logic rstLo;
    logic rstHi;
    logic selVal;
  } cmd_t;

  localparam int TBL_LEN = 44;

  function automatic step_t mkStep(input op_e op, input logic [15:0] a,
                                   input logic [15:0] b, input logic [23:0] n);
    step_t s;
    s.op = op;
    s.a  = a;
    s.b  = b;
    s.n  = n;
    return s;
  endfunction

  function automatic logic [17:0] map16(input logic [15:0] w);
    return {w[15:8], 1'b1, w[7:0], 1'b1};
  endfunction

  function automatic logic [15:0] unmap18(input logic [17:0] r);
    return {r[17:10], r[8:1]};
  endfunction

  // Register/value pairs: entries 0-11, 12-36, 37-40, 41-43 form four groups
  function automatic logic [31:0] pairRom(input logic [5:0] i);
    case (i)
      6'd0:  return 32'h0060_2700;
      6'd1:  return 32'h0008_0808;
      6'd2:  return 32'h0090_001A;
      6'd3:  return 32'h0007_0001;
      6'd4:  return 32'h0017_0001;
      6'd5:  return 32'h0019_0000;
      6'd6:  return 32'h0010_17B0;
      6'd7:  return 32'h0011_0116;
      6'd8:  return 32'h0012_0198;
      6'd9:  return 32'h0013_1400;
      6'd10: return 32'h0029_000C;
      6'd11: return 32'h0012_01B8;
      6'd12: return 32'h0030_0307;
      6'd13: return 32'h0031_0303;
      6'd14: return 32'h0032_0603;
      6'd15: return 32'h0033_0202;
      6'd16: return 32'h0034_0202;
      6'd17: return 32'h0035_0202;
      6'd18: return 32'h0036_1F1F;
      6'd19: return 32'h0037_0303;
      6'd20: return 32'h0038_0303;
      6'd21: return 32'h0039_0603;
      6'd22: return 32'h003A_0202;
      6'd23: return 32'h003B_0102;
      6'd24: return 32'h003C_0204;
      6'd25: return 32'h003D_0000;
      6'd26: return 32'h0001_0100;
      6'd27: return 32'h0002_0300;
      6'd28: return 32'h0003_5028;
      6'd29: return 32'h0020_00EF;
      6'd30: return 32'h0021_0000;
      6'd31: return 32'h0004_0000;
      6'd32: return 32'h0009_0000;
      6'd33: return 32'h000A_0008;
      6'd34: return 32'h000C_0000;
      6'd35: return 32'h000D_0000;
      6'd36: return 32'h0015_8000;
      6'd37: return 32'h0061_0001;
      6'd38: return 32'h0092_0100;
      6'd39: return 32'h0093_0001;
      6'd40: return 32'h0007_0021;
      6'd41: return 32'h0010_16B0;
      6'd42: return 32'h0011_0111;
      6'd43: return 32'h0007_0061;
      default: return 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/panel_init_dp.sv
module panel_init_dp
  import panel_init_pkg::*;
#(
  parameter int          CLK_PER_MS = 100000,
  parameter int          H_RES      = 320,
  parameter int          V_RES      = 240,
  parameter int          LINE_WORDS = 256,
  parameter logic [15:0] ID_CODE    = 16'h1505
) (
  input  logic        clk,
  input  logic        rstN,
  input  cmd_t        cmd,
  input  logic [17:0] rdWord,
  output op_e         stepOp,
  output logic        cntOne,
  output logic        cntZero,
  output logic        idMatch,
  output logic [17:0] wrWord,
  output logic        panelResetN
);

  localparam int          CLEAR_WORDS = H_RES * LINE_WORDS;
  localparam int          CNT_MAX     = (CLEAR_WORDS > 255) ? CLEAR_WORDS : 255;
  localparam int          CNT_W       = $clog2(CNT_MAX + 1);
  localparam int          PRE_W       = (CLK_PER_MS > 2) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [15:0] WIN_Y0      = 16'(239 - (V_RES - 1));
  localparam logic [15:0] WIN_X1      = 16'(H_RES - 1);
  localparam logic [23:0] CLR_N       = 24'(CLEAR_WORDS);

  logic [4:0]       stepIdx;
  logic [CNT_W-1:0] cnt;
  logic [PRE_W-1:0] pre;
  logic [5:0]       tblPtr;
  logic             rstReg;
  step_t            step;
  logic [31:0]      curPair;

  function automatic step_t progStep(input logic [4:0] idx);
    case (idx)
      5'd0:  return mkStep(OP_RST_LO, 16'h0, 16'h0, 24'd0);
      5'd1:  return mkStep(OP_WAIT,   16'h0, 16'h0, 24'd2);
      5'd2:  return mkStep(OP_RST_HI, 16'h0, 16'h0, 24'd0);
      5'd3:  return mkStep(OP_WAIT,   16'h0, 16'h0, 24'd1);
      5'd4:  return mkStep(OP_FILL,   16'h0, 16'h0, 24'd4);
      5'd5:  return mkStep(OP_RDCHK,  16'h0, ID_CODE, 24'd0);
      5'd6:  return mkStep(OP_FILL,   16'h0, 16'h0, 24'd4);
      5'd7:  return mkStep(OP_WR,     16'h00A4, 16'h0001, 24'd1);
      5'd8:  return mkStep(OP_WAIT,   16'h0, 16'h0, 24'd10);
      5'd9:  return mkStep(OP_TBL,    16'd0, 16'h0, 24'd12);
      5'd10: return mkStep(OP_WAIT,   16'h0, 16'h0, 24'd100);
      5'd11: return mkStep(OP_TBL,    16'd12, 16'h0, 24'd25);
      5'd12: return mkStep(OP_WR,     16'h0050, WIN_Y0, 24'd1);
      5'd13: return mkStep(OP_WR,     16'h0051, 16'h00EF, 24'd1);
      5'd14: return mkStep(OP_WR,     16'h0052, 16'h0000, 24'd1);
      5'd15: return mkStep(OP_WR,     16'h0053, WIN_X1, 24'd1);
      5'd16: return mkStep(OP_TBL,    16'd37, 16'h0, 24'd4);
      5'd17: return mkStep(OP_WAIT,   16'h0, 16'h0, 24'd10);
      5'd18: return mkStep(OP_TBL,    16'd41, 16'h0, 24'd3);
      5'd19: return mkStep(OP_WAIT,   16'h0, 16'h0, 24'd40);
      5'd20: return mkStep(OP_WR,     16'h0020, 16'h0000, 24'd1);
      5'd21: return mkStep(OP_WR,     16'h0021, 16'h0000, 24'd1);
      5'd22: return mkStep(OP_FILL,   16'h0022, 16'h0000, CLR_N);
      5'd23: return mkStep(OP_WR,     16'h0020, 16'h0000, 24'd1);
      5'd24: return mkStep(OP_WR,     16'h0021, 16'h0000, 24'd1);
      5'd25: return mkStep(OP_WR,     16'h0007, 16'h0173, 24'd1);
      5'd26: return mkStep(OP_WAIT,   16'h0, 16'h0, 24'd40);
      5'd27: return mkStep(OP_IDX,    16'h0022, 16'h0, 24'd0);
      5'd28: return mkStep(OP_WAIT,   16'h0, 16'h0, 24'd100);
      default: return mkStep(OP_END,  16'h0, 16'h0, 24'd0);
    endcase
  endfunction

  always_comb begin
    step    = progStep(stepIdx);
    stepOp  = step.op;
    curPair = (step.op == OP_TBL) ? pairRom(tblPtr) : {step.a, step.b};
    wrWord  = map16(cmd.selVal ? curPair[15:0] : curPair[31:16]);
    idMatch = (unmap18(rdWord) == step.b);
    cntOne  = (cnt == CNT_W'(1));
    cntZero = (cnt == '0);
    panelResetN = rstReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepIdx <= '0;
      cnt     <= '0;
      pre     <= '0;
      tblPtr  <= '0;
      rstReg  <= 1'b1;
    end else begin
      if (cmd.startRun)      stepIdx <= '0;
      else if (cmd.nextStep) stepIdx <= stepIdx + 5'd1;

      if (cmd.loadCnt) begin
        cnt    <= step.n[CNT_W-1:0];
        pre    <= '0;
        tblPtr <= step.a[5:0];
      end else if (cmd.decCnt) begin
        cnt    <= cnt - CNT_W'(1);
        tblPtr <= tblPtr + 6'd1;
      end else if (cmd.tick && !cntZero) begin
        if (pre == PRE_W'(CLK_PER_MS - 1)) begin
          pre <= '0;
          cnt <= cnt - CNT_W'(1);
        end else begin
          pre <= pre + PRE_W'(1);
        end
      end

      if (cmd.rstLo)      rstReg <= 1'b0;
      else if (cmd.rstHi) rstReg <= 1'b1;
    end
  end

endmodule

// File: rtl/panel_init_ctrl.sv
module panel_init_ctrl
  import panel_init_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic busReady,
  input  op_e  stepOp,
  input  logic cntOne,
  input  logic cntZero,
  input  logic idMatch,
  output cmd_t cmd,
  output logic idxWr,
  output logic datWr,
  output logic datRd,
  output logic doneO,
  output logic errO
);

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_IDX, S_DAT, S_RIDX, S_RRD, S_RCMP,
    S_XIDX, S_WAIT, S_DONE, S_ERR
  } state_e;

  state_e state, nextState;

  always_comb begin
    cmd       = '0;
    idxWr     = 1'b0;
    datWr     = 1'b0;
    datRd     = 1'b0;
    nextState = state;
    case (state)
      S_IDLE, S_DONE, S_ERR: begin
        if (start) begin
          cmd.startRun = 1'b1;
          nextState    = S_FETCH;
        end
      end
      S_FETCH: begin
        case (stepOp)
          OP_RST_LO: begin cmd.rstLo = 1'b1; cmd.nextStep = 1'b1; end
          OP_RST_HI: begin cmd.rstHi = 1'b1; cmd.nextStep = 1'b1; end
          OP_WAIT:   begin cmd.loadCnt = 1'b1; nextState = S_WAIT; end
          OP_WR, OP_FILL, OP_TBL: begin
            cmd.loadCnt = 1'b1;
            nextState   = S_IDX;
          end
          OP_RDCHK:  nextState = S_RIDX;
          OP_IDX:    nextState = S_XIDX;
          OP_END:    nextState = S_DONE;
          default:   nextState = S_ERR;
        endcase
      end
      S_IDX: begin
        if (busReady) begin
          idxWr     = 1'b1;
          nextState = S_DAT;
        end
      end
      S_DAT: begin
        cmd.selVal = 1'b1;
        if (busReady) begin
          datWr      = 1'b1;
          cmd.decCnt = 1'b1;
          if (cntOne) begin
            cmd.nextStep = 1'b1;
            nextState    = S_FETCH;
          end else begin
            nextState = S_IDX;
          end
        end
      end
      S_RIDX: begin
        if (busReady) begin
          idxWr     = 1'b1;
          nextState = S_RRD;
        end
      end
      S_RRD: begin
        if (busReady) begin
          datRd     = 1'b1;
          nextState = S_RCMP;
        end
      end
      S_RCMP: begin
        if (idMatch) begin
          cmd.nextStep = 1'b1;
          nextState    = S_FETCH;
        end else begin
          nextState = S_ERR;
        end
      end
      S_XIDX: begin
        if (busReady) begin
          idxWr        = 1'b1;
          cmd.nextStep = 1'b1;
          nextState    = S_FETCH;
        end
      end
      S_WAIT: begin
        if (cntZero) begin
          cmd.nextStep = 1'b1;
          nextState    = S_FETCH;
        end else begin
          cmd.tick = 1'b1;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  assign doneO = (state == S_DONE);
  assign errO  = (state == S_ERR);

endmodule

// File: rtl/panel_init_seq.sv
module panel_init_seq
  import panel_init_pkg::*;
#(
  parameter int          CLK_PER_MS = 100000,
  parameter int          H_RES      = 320,
  parameter int          V_RES      = 240,
  parameter int          LINE_WORDS = 256,
  parameter logic [15:0] ID_CODE    = 16'h1505
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        busReady,
  input  logic [17:0] rdWord,
  output logic        idxWr,
  output logic        datWr,
  output logic        datRd,
  output logic [17:0] wrWord,
  output logic        panelResetN,
  output logic        doneO,
  output logic        errO
);

  cmd_t cmd;
  op_e  stepOp;
  logic cntOne, cntZero, idMatch;

  panel_init_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .busReady(busReady),
    .stepOp(stepOp), .cntOne(cntOne), .cntZero(cntZero), .idMatch(idMatch),
    .cmd(cmd), .idxWr(idxWr), .datWr(datWr), .datRd(datRd),
    .doneO(doneO), .errO(errO)
  );

  panel_init_dp #(
    .CLK_PER_MS(CLK_PER_MS), .H_RES(H_RES), .V_RES(V_RES),
    .LINE_WORDS(LINE_WORDS), .ID_CODE(ID_CODE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .rdWord(rdWord),
    .stepOp(stepOp), .cntOne(cntOne), .cntZero(cntZero), .idMatch(idMatch),
    .wrWord(wrWord), .panelResetN(panelResetN)
  );

endmodule

// File: rtl/panel_init_chk.sv
module panel_init_chk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        busReady,
  input logic [17:0] rdWord,
  input logic        idxWr,
  input logic        datWr,
  input logic        datRd,
  input logic [17:0] wrWord,
  input logic        panelResetN,
  input logic        doneO,
  input logic        errO
);

  logic lastIdx;
  logic anyStrobe;
  assign anyStrobe = idxWr | datWr | datRd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                lastIdx <= 1'b0;
    else if (idxWr)           lastIdx <= 1'b1;
    else if (datWr || datRd)  lastIdx <= 1'b0;
  end

  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({idxWr, datWr, datRd}));

  a_r8_only_when_ready: assert property (@(posedge clk) disable iff (!rstN)
    anyStrobe |-> busReady);

  a_r2_guard_lines: assert property (@(posedge clk) disable iff (!rstN)
    (idxWr || datWr) |-> (wrWord[0] && wrWord[9]));

  a_r3_data_after_index: assert property (@(posedge clk) disable iff (!rstN)
    (datWr || datRd) |-> lastIdx);

  a_r1_quiet_in_reset: assert property (@(posedge clk) disable iff (!rstN)
    !panelResetN |-> !anyStrobe);

  a_r4_quiet_on_error: assert property (@(posedge clk) disable iff (!rstN)
    errO |-> !anyStrobe);

  a_r9_error_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errO && !start) |=> errO);

  a_r7_done_held: assert property (@(posedge clk) disable iff (!rstN)
    (doneO && !start) |=> doneO);

  a_r7_quiet_when_done: assert property (@(posedge clk) disable iff (!rstN)
    doneO |-> !anyStrobe);

  a_r9_start_clears_error: assert property (@(posedge clk) disable iff (!rstN)
    (errO && start) |=> !errO);

endmodule

bind panel_init_seq panel_init_chk u_chk (.*);

// File: tb/panel_init_seq_tb.sv
module panel_init_seq_tb;

  localparam int P    = 20;
  localparam int LW   = 4;
  localparam int HR   = 320;
  localparam int VR   = 240;
  localparam int MAXE = 4096;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        busReady = 1'b0;
  logic [17:0] rdWord = '0;
  logic        idxWr, datWr, datRd, panelResetN, doneO, errO;
  logic [17:0] wrWord;

  always #5 clk = ~clk;

  panel_init_seq #(.CLK_PER_MS(P), .H_RES(HR), .V_RES(VR), .LINE_WORDS(LW)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .busReady(busReady), .rdWord(rdWord),
    .idxWr(idxWr), .datWr(datWr), .datRd(datRd), .wrWord(wrWord),
    .panelResetN(panelResetN), .doneO(doneO), .errO(errO)
  );

  int          checks = 0;
  int          fails = 0;
  longint      cyc = 0;
  longint      lastEvt = 0;
  longint      lowStart = 0;
  logic        prevRst = 1'b1;
  int          expType [MAXE];
  logic [17:0] expWord [MAXE];
  int          expGap  [MAXE];
  string       expTag  [MAXE];
  int          expCount = 0;
  int          expIdx = 0;
  logic [15:0] idResp = 16'h1505;
  int          readyPct = 70;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1 busReady = (($urandom % 100) < readyPct);
  end

  function automatic logic [17:0] bmap(input int w);
    return 18'(((w & 255) << 1) | 1 | (1 << 9) | (((w >> 8) & 255) << 10));
  endfunction

  function automatic logic [31:0] btab(input int i);
    logic [31:0] t [44] = '{
      32'h0060_2700, 32'h0008_0808, 32'h0090_001A, 32'h0007_0001, 32'h0017_0001,
      32'h0019_0000, 32'h0010_17B0, 32'h0011_0116, 32'h0012_0198, 32'h0013_1400,
      32'h0029_000C, 32'h0012_01B8,
      32'h0030_0307, 32'h0031_0303, 32'h0032_0603, 32'h0033_0202, 32'h0034_0202,
      32'h0035_0202, 32'h0036_1F1F, 32'h0037_0303, 32'h0038_0303, 32'h0039_0603,
      32'h003A_0202, 32'h003B_0102, 32'h003C_0204, 32'h003D_0000, 32'h0001_0100,
      32'h0002_0300, 32'h0003_5028, 32'h0020_00EF, 32'h0021_0000, 32'h0004_0000,
      32'h0009_0000, 32'h000A_0008, 32'h000C_0000, 32'h000D_0000, 32'h0015_8000,
      32'h0061_0001, 32'h0092_0100, 32'h0093_0001, 32'h0007_0021,
      32'h0010_16B0, 32'h0011_0111, 32'h0007_0061};
    return t[i];
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input int t, input logic [17:0] w, input int g, input string tag);
    expType[expCount] = t;
    expWord[expCount] = w;
    expGap[expCount]  = g;
    expTag[expCount]  = tag;
    expCount++;
  endtask

  task automatic pushW(input int r, input int v, input int g, input string tag);
    push(0, bmap(r), g, tag);
    push(1, bmap(v), 0, tag);
  endtask

  task automatic pushTbl(input int first, input int cnt, input int g, input string tag);
    for (int i = 0; i < cnt; i++) begin
      logic [31:0] e;
      e = btab(first + i);
      pushW(int'(e[31:16]), int'(e[15:0]), (i == 0) ? g : 0, tag);
    end
  endtask

  task automatic build(input bit good);
    expCount = 0;
    expIdx   = 0;
    for (int k = 0; k < 4; k++) pushW(0, 0, (k == 0) ? 1 : 0, (k == 0) ? "R1" : "R4");
    push(0, bmap(0), 0, "R3");
    push(2, '0, 0, "R3");
    if (good) begin
      for (int k = 0; k < 4; k++) pushW(0, 0, 0, "R5");
      pushW(16'hA4, 1, 0, "R5");
      pushTbl(0, 12, 10, "R5");
      pushTbl(12, 25, 100, "R5");
      pushW(16'h50, 239 - (VR - 1), 0, "R5");
      pushW(16'h51, 16'hEF, 0, "R5");
      pushW(16'h52, 0, 0, "R5");
      pushW(16'h53, HR - 1, 0, "R5");
      pushTbl(37, 4, 0, "R5");
      pushTbl(41, 3, 10, "R5");
      pushW(16'h20, 0, 40, "R6");
      pushW(16'h21, 0, 0, "R6");
      for (int k = 0; k < HR * LW; k++) pushW(16'h22, 0, 0, "R6");
      pushW(16'h20, 0, 0, "R6");
      pushW(16'h21, 0, 0, "R6");
      pushW(16'h07, 16'h0173, 0, "R6");
      push(0, bmap(16'h0022), 40, "R7");
    end
  endtask

  // Command monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rstN) begin
      int n;
      int t;
      n = int'(idxWr) + int'(datWr) + int'(datRd);
      if (prevRst && !panelResetN) lowStart = cyc;
      if (!prevRst && panelResetN) begin
        check((cyc - lowStart) >= 2 * P, "R1", "reset low cycles", cyc - lowStart, 2 * P);
        lastEvt = cyc;
      end
      prevRst = panelResetN;
      if (n > 0) begin
        check(n == 1, "R8", "strobes in one cycle", n, 1);
        check(busReady, "R8", "strobe without ready", 0, 1);
        t = idxWr ? 0 : (datWr ? 1 : 2);
        if (t != 2) check(wrWord[0] && wrWord[9], "R2", "guard lines", wrWord, 18'h201);
        if (expIdx < expCount) begin
          check(t == expType[expIdx], expTag[expIdx], "command kind", t, expType[expIdx]);
          if (t != 2)
            check(wrWord == expWord[expIdx], expTag[expIdx], "mapped word", wrWord, expWord[expIdx]);
          if (expGap[expIdx] > 0)
            check((cyc - lastEvt) >= expGap[expIdx] * P, expTag[expIdx], "pause cycles",
                  cyc - lastEvt, expGap[expIdx] * P);
        end else begin
          check(0, errO ? "R4" : "R7", "command past end of sequence", expIdx, expCount);
        end
        expIdx++;
        lastEvt = cyc;
        if (datRd) rdWord = bmap(idResp) & ~18'h201;
      end
    end
  end

  task automatic pulseStart;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic waitEnd;
    while (!doneO && !errO) @(negedge clk);
  endtask

  task automatic goodRun(input int pct, input bit poke);
    readyPct = pct;
    idResp   = 16'h1505;
    build(1);
    pulseStart();
    check(!errO && !doneO, "R9", "flags after start", {errO, doneO}, 0);
    if (poke) begin
      repeat (300) @(negedge clk);
      pulseStart();                      // R10: ignored while busy
      repeat (1500) @(negedge clk);
      pulseStart();
    end
    waitEnd();
    check(doneO && !errO, "R7", "done at end", {doneO, errO}, 2'b10);
    check(expIdx == expCount, "R6", "command count", expIdx, expCount);
    check((cyc - lastEvt) >= 100 * P, "R7", "pause before done", cyc - lastEvt, 100 * P);
    repeat (40) @(negedge clk);
    check(doneO, "R7", "done held", doneO, 1);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    check(panelResetN == 1'b1, "R1", "reset line idle", panelResetN, 1);
    check(!doneO && !errO, "R9", "flags in reset", {doneO, errO}, 0);
    check(!idxWr && !datWr && !datRd, "R8", "strobes in reset", {idxWr, datWr, datRd}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!doneO && !errO && panelResetN, "R9", "idle after reset", {doneO, errO, panelResetN}, 1);

    goodRun(70, 1'b1);

    // Wrong identity
    readyPct = 40;
    idResp   = 16'h1504;
    build(0);
    pulseStart();
    check(!doneO, "R9", "done cleared by start", doneO, 0);
    waitEnd();
    check(errO && !doneO, "R4", "error on bad id", {errO, doneO}, 2'b10);
    check(expIdx == expCount, "R4", "commands before abort", expIdx, expCount);
    repeat (100) @(negedge clk);
    check(errO, "R9", "error sticky", errO, 1);
    check(expIdx == expCount, "R4", "no commands after abort", expIdx, expCount);

    // Recover with a fast bus
    readyPct = 95;
    idResp   = 16'h1505;
    build(1);
    pulseStart();
    check(!errO, "R9", "error cleared by start", errO, 0);
    waitEnd();
    check(doneO && !errO, "R7", "done after recovery", {doneO, errO}, 2'b10);
    check(expIdx == expCount, "R6", "command count after recovery", expIdx, expCount);

    goodRun(30, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog expired actual=%0d expected=%0d", expIdx, expCount);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule